// File: doc/BRIEF.md
# Two-wire EEPROM slave responder

This block answers on a two-wire serial bus the way a small serial EEPROM does. It keeps a byte array inside the chip and samples the bus clock and data lines with the system clock. It finds start and stop conditions and compares the device address byte against a fixed nibble and three strap inputs. It acknowledges the bytes it accepts and serves byte writes, page writes, random reads and sequential reads. The data line is open-drain: the block only ever pulls it low or lets it go.

A parameter selects which strap pins take part in the match, so one design covers the variants that decode all three pins, two of them, one of them or none. Write data is held in a page buffer. A stop condition starts a modelled internal write cycle. The buffer reaches the array only when that cycle ends, and during the cycle the block will not acknowledge its own address.

The array size is limited to 256 bytes, so a single word-address byte follows a write command.

Top module: `eeslv_top`

## Requirements
- R1: After reset the data line is released, and every array location reads 0xFF.
- R2: The address byte is matched only if its bits 7..4 are 1010 and its bits 3..1 (strap pin 2, pin 1, pin 0) equal the strap inputs at the positions enabled by the pin-mask parameter. Disabled positions are ignored. Bit 0 selects read (1) or write (0).
- R3: On a matched address, and on every byte received in a write, the data line is pulled low during the ninth clock. After an address that does not match, the line stays released until the next start.
- R4: In a write, the first byte after the address sets the word pointer. A written byte read back later returns the same value, shifted out most significant bit first.
- R5: In a page write, the pointer advances only in its page-offset bits (page size 8, 16 or 32 bytes), so the data wraps inside the current page.
- R6: In a read, the pointer advances over the full array and wraps from the top address to 0. Bytes keep coming while the master acknowledges, and the data line is released after the master does not acknowledge.
- R7: A stop that ends a write carrying data starts a busy period of exactly BUSY_CYCLES clock cycles. During it the device address is not acknowledged. The buffered bytes reach the array when the period ends.
- R8: A write that carries only the word address, followed by a stop or a repeated start, sets the pointer and starts no busy period.
- R9: A start at any point returns the block to the address phase and discards write data that is buffered but not committed. A stop at any point returns the block to idle with the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| strap_i | input | 3 | Strap pins: bit 2 = pin 2, bit 1 = pin 1, bit 0 = pin 0 |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench runs writes against three kinds of address byte: one that matches exactly, one that differs only in the masked-off pin 0, and ones with a wrong strap bit or a wrong fixed nibble. This separates real matching from a plain compare of all bits. Writes use a single byte, a run that crosses a page end, and a run that wraps at the top of the array. Reads start from several addresses, so wrap inside the page on writes is told apart from linear wrap on reads. Address-only writes, repeated starts after buffered data, and conditions in the middle of a byte show whether the busy period starts only when it should and whether aborted data is thrown away.

// File: rtl/eeslv_pkg.sv
// Shared types and helpers for the two-wire EEPROM slave.
// Assumes the address byte layout: [7:4] fixed nibble, [3:1] strap pins 2..0, [0] read/write.
package eeslv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEV   = 3'd1,
        PH_WADDR = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4
    } phase_t;

    localparam logic [3:0] DEV_NIBBLE = 4'b1010;

    // True when an address byte selects this device under the given pin mask.
    function automatic logic dev_hit(input logic [7:0] abyte,
                                     input logic [2:0] strap,
                                     input logic [2:0] pin_mask);
        return (abyte[7:4] == DEV_NIBBLE) &&
               (((abyte[3:1] ^ strap) & pin_mask) == 3'b000);
    endfunction

endpackage

// File: rtl/eeslv_cond.sv
// Bus line conditioner: brings both lines into the clock domain and reports
// clock edges and start/stop conditions as one-cycle pulses.
// Assumes the bus runs much slower than clk (several clk cycles per bus phase).
module eeslv_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_sh;
    logic [DEPTH-1:0] sda_sh;

    // Shift both lines through the synchronizer; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
            sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
        end
    end

    // Decode levels, edges and bus conditions from the last two stages.
    always_comb begin
        scl_lvl   = scl_sh[DEPTH-2];
        sda_lvl   = sda_sh[DEPTH-2];
        scl_rise  = scl_sh[DEPTH-2] & ~scl_sh[DEPTH-1];
        scl_fall  = ~scl_sh[DEPTH-2] & scl_sh[DEPTH-1];
        start_det = scl_sh[DEPTH-2] & scl_sh[DEPTH-1] & sda_sh[DEPTH-1] & ~sda_sh[DEPTH-2];
        stop_det  = scl_sh[DEPTH-2] & scl_sh[DEPTH-1] & ~sda_sh[DEPTH-1] & sda_sh[DEPTH-2];
    end
endmodule

// File: rtl/eeslv_store.sv
// Byte array with a one-page write buffer and a modelled internal write cycle.
// Bytes written land in the buffer; a commit request starts the busy timer when
// the buffer holds data, and the buffer is copied into the array as the timer
// expires. A discard request drops buffered bytes while no cycle is running.
// Assumes MEM_BYTES is a power of two larger than PAGE_BYTES.
module eeslv_store #(
    parameter int MEM_BYTES   = 256,
    parameter int PAGE_BYTES  = 8,
    parameter int BUSY_CYCLES = 600
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(MEM_BYTES)-1:0] wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic                         commit_req,
    input  logic                         discard_req,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         busy
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

    logic [7:0]            mem   [MEM_BYTES];
    logic [7:0]            pbuf  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [PG_W-1:0]       pbase;
    logic [CNT_W-1:0]      cnt;
    logic                  expire;

    assign expire  = busy && (cnt == CNT_W'(1));
    assign rd_data = mem[rd_addr];

    // Busy timer: loads on a commit with buffered data, counts down to expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (expire) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (commit_req && (pvalid != '0)) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(BUSY_CYCLES);
        end
    end

    // Page buffer: collects bytes, clears on expiry or on a discard while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
            pbase  <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
        end else if (expire) begin
            pvalid <= '0;
        end else if (!busy && discard_req) begin
            pvalid <= '0;
        end else if (wr_en && !busy) begin
            pbuf[wr_addr[OFF_W-1:0]]   <= wr_data;
            pvalid[wr_addr[OFF_W-1:0]] <= 1'b1;
            pbase                      <= wr_addr[ADDR_W-1:OFF_W];
        end
    end

    // Array: erased at reset, receives every valid buffered byte on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < MEM_BYTES; j++) mem[j] <= 8'hFF;
        end else if (expire) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (pvalid[k]) mem[{pbase, OFF_W'(k)}] <= pbuf[k];
            end
        end
    end
endmodule

// File: rtl/eeslv_link.sv
// Bit/byte protocol engine of the slave: receives address and write bytes,
// drives acknowledges, shifts read data out, and keeps the word pointer.
// Data changes only after a detected clock fall; the input is sampled on a clock rise.
// Assumes conditioned inputs from eeslv_cond and combinational read data.
module eeslv_link
    import eeslv_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         OFF_W    = 3,
    parameter logic [2:0] PIN_MASK = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              sda_pull,
    output phase_t            phase,
    output logic [3:0]        bitcnt
);
    logic [7:0] sr;
    logic [7:0] tx;
    logic       is_rd;
    logic       rx_phase;

    assign rx_phase = (phase == PH_DEV) || (phase == PH_WADDR) || (phase == PH_WDATA);

    // Write strobe: a complete data byte at the fall that opens its ack clock.
    always_comb begin
        wr_en   = (phase == PH_WDATA) && scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det;
        wr_data = sr;
    end

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            sr       <= '0;
            tx       <= '0;
            ptr      <= '0;
            is_rd    <= 1'b0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_DEV;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (rx_phase) begin
            if (scl_rise && (bitcnt < 4'd8)) begin
                sr     <= {sr[6:0], sda_lvl};
                bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && (bitcnt == 4'd8)) begin
                bitcnt <= 4'd9;
                unique case (phase)
                    PH_DEV: begin
                        if (dev_hit(sr, strap, PIN_MASK) && !busy) begin
                            sda_pull <= 1'b1;
                            is_rd    <= sr[0];
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_WADDR: begin
                        ptr      <= sr[ADDR_W-1:0];
                        sda_pull <= 1'b1;
                    end
                    default: begin
                        ptr      <= {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + OFF_W'(1)};
                        sda_pull <= 1'b1;
                    end
                endcase
            end else if (scl_fall && (bitcnt == 4'd9)) begin
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                if (phase == PH_DEV && is_rd) begin
                    phase    <= PH_RDATA;
                    tx       <= rd_data;
                    sda_pull <= ~rd_data[7];
                    ptr      <= ptr + ADDR_W'(1);
                end else if (phase == PH_DEV) begin
                    phase <= PH_WADDR;
                end else begin
                    phase <= PH_WDATA;
                end
            end
        end else if (phase == PH_RDATA) begin
            if (scl_rise) begin
                if (bitcnt < 4'd8) begin
                    bitcnt <= bitcnt + 4'd1;
                end else if (bitcnt == 4'd8) begin
                    if (sda_lvl) phase <= PH_IDLE;
                    else         bitcnt <= 4'd9;
                end
            end else if (scl_fall) begin
                if (bitcnt == 4'd9) begin
                    tx       <= rd_data;
                    sda_pull <= ~rd_data[7];
                    ptr      <= ptr + ADDR_W'(1);
                    bitcnt   <= '0;
                end else if (bitcnt == 4'd8) begin
                    sda_pull <= 1'b0;
                end else if (bitcnt != 4'd0) begin
                    sda_pull <= ~tx[6];
                    tx       <= {tx[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/eeslv_top.sv
// Two-wire serial EEPROM slave: conditioner, protocol engine and storage.
// The data output is open-drain: sda_pull_o high means the line is pulled low.
// Assumes MEM_BYTES <= 256 (one word-address byte) and PAGE_BYTES of 8, 16 or 32.
module eeslv_top #(
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 8,
    parameter logic [2:0] PIN_MASK    = 3'b110,
    parameter int         BUSY_CYCLES = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o
);
    import eeslv_pkg::*;

    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int OFF_W  = $clog2(PAGE_BYTES);

    logic              scl_s;
    logic              sda_s;
    logic              scl_r;
    logic              scl_f;
    logic              start_d;
    logic              stop_d;
    logic              busy;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] ptr;
    phase_t            phase;
    logic [3:0]        bitcnt;

    eeslv_cond #(.SYNC_STAGES(2)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_r),
        .scl_fall  (scl_f),
        .start_det (start_d),
        .stop_det  (stop_d)
    );

    eeslv_link #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .PIN_MASK (PIN_MASK)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_r),
        .scl_fall  (scl_f),
        .start_det (start_d),
        .stop_det  (stop_d),
        .strap     (strap_i),
        .busy      (busy),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_o),
        .phase     (phase),
        .bitcnt    (bitcnt)
    );

    eeslv_store #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (ptr),
        .wr_data     (wr_data),
        .commit_req  (stop_d),
        .discard_req (start_d),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .busy        (busy)
    );
endmodule

// File: rtl/eeslv_chk.sv
// Property checker for eeslv_top, attached by the bind below.
module eeslv_chk
    import eeslv_pkg::*;
#(
    parameter int BUSY_CYCLES = 600
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input phase_t     phase,
    input logic [3:0] bitcnt,
    input logic       busy,
    input logic       sda_pull
);
    int busy_run;

    // Length of the current busy stretch, counted independently of the store.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    p_pull_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_lvl);

    p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_DEV) |-> !sda_pull);

    p_busy_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (phase == PH_IDLE));

    p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == BUSY_CYCLES));

    p_start_rearms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_DEV && bitcnt == 4'd0));

    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (phase == PH_IDLE && !sda_pull));
endmodule

bind eeslv_top eeslv_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_s),
    .start_det (start_d),
    .stop_det  (stop_d),
    .phase     (phase),
    .bitcnt    (bitcnt),
    .busy      (busy),
    .sda_pull  (sda_pull_o)
);

// File: tb/eeslv_top_tb.sv
// Scoreboard bench: bus-master tasks push expected acks and bytes into a queue,
// a monitor pops and compares them against what the master observes on the bus.
module eeslv_top_tb;
    localparam int         BUSY = 600;
    localparam int         Q    = 10;
    localparam logic [2:0] AOK  = 3'b101;
    localparam logic [2:0] AOK0 = 3'b100;
    localparam logic [2:0] ABAD = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_pull;

    eeslv_top #(
        .MEM_BYTES(256), .PAGE_BYTES(8), .PIN_MASK(3'b110), .BUSY_CYCLES(BUSY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_i(AOK), .sda_pull_o(sda_pull)
    );

    always #2.5 clk = ~clk;

    typedef struct { string tag; logic [7:0] val; } sb_item_t;
    sb_item_t   exp_q[$];
    logic [7:0] obs_q[$];
    int n_checks = 0;
    int n_err = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each observation with the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) check("SB-empty", o, 8'hXX);
                else begin
                    sb_item_t e;
                    e = exp_q.pop_front();
                    check(e.tag, o, e.val);
                end
            end
        end
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq(); endtask
    task automatic bus_stop(); m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq(); endtask
    task automatic put_bit(input logic b); m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); endtask
    task automatic get_bit(output logic b); m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq(); endtask

    function automatic logic [7:0] devb(input logic [2:0] a, input logic rw);
        return {4'b1010, a, rw};
    endfunction

    // Send a byte; expected ack (1 = acknowledged) goes to the scoreboard.
    task automatic tx_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic bit_in;
        exp_q.push_back('{tag, {7'd0, exp_ack}});
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(bit_in);
        obs_q.push_back({7'd0, ~bit_in});
    endtask

    // Receive a byte MSB first and answer with ack (mack=1) or nack.
    task automatic rx_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] v;
        exp_q.push_back('{tag, exp});
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~mack);
        obs_q.push_back(v);
    endtask

    task automatic set_ptr(input logic [7:0] a, input string tag);
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b1, tag);
        tx_byte(a, 1'b1, tag);
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, tag);
    endtask

    task automatic wait_busy(); repeat (BUSY + 60) @(negedge clk); endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(negedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 sda released", {7'd0, sda_pull}, 8'h00);

        // R1: erased content at pointer 0
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, "R2 match");
        rx_byte(8'hFF, 1'b0, "R1 erased");
        bus_stop();

        // R3/R4/R7: byte write, busy refusal, readback
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b1, "R3 addr ack");
        tx_byte(8'h10, 1'b1, "R3 word ack");
        tx_byte(8'hA5, 1'b1, "R3 data ack");
        bus_stop();
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b0, "R7 busy nack");
        bus_stop();
        wait_busy();
        set_ptr(8'h10, "R7 ack after busy");
        rx_byte(8'hA5, 1'b0, "R4 readback");
        bus_stop();

        // R2/R5: pin 0 masked off; page write wraps inside page 0x28..0x2F
        bus_start();
        tx_byte(devb(AOK0, 1'b0), 1'b1, "R2 masked pin");
        tx_byte(8'h2E, 1'b1, "R5 word");
        tx_byte(8'h11, 1'b1, "R5 d0");
        tx_byte(8'h22, 1'b1, "R5 d1");
        tx_byte(8'h33, 1'b1, "R5 d2");
        tx_byte(8'h44, 1'b1, "R5 d3");
        bus_stop();
        wait_busy();
        set_ptr(8'h28, "R5 ptr");
        rx_byte(8'h33, 1'b1, "R5 wrap 0x28");
        rx_byte(8'h44, 1'b1, "R5 wrap 0x29");
        rx_byte(8'hFF, 1'b0, "R5 0x2A");
        bus_stop();
        set_ptr(8'h2E, "R6 ptr");
        rx_byte(8'h11, 1'b1, "R6 0x2E");
        rx_byte(8'h22, 1'b1, "R6 0x2F");
        rx_byte(8'hFF, 1'b0, "R6 crosses page 0x30");
        bus_stop();

        // R2/R3: mismatched strap and nibble, no drive afterwards
        bus_start();
        tx_byte(devb(ABAD, 1'b0), 1'b0, "R2 strap mismatch");
        tx_byte(8'h00, 1'b0, "R3 silent after mismatch");
        bus_stop();
        bus_start();
        tx_byte({4'b1011, AOK, 1'b0}, 1'b0, "R2 nibble mismatch");
        bus_stop();

        // R6: read wraps from 0xFF to 0x00; release after nack
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b1, "R6 wr");
        tx_byte(8'hFF, 1'b1, "R6 word");
        tx_byte(8'h5A, 1'b1, "R6 d0");
        tx_byte(8'h6B, 1'b1, "R6 d1");
        bus_stop();
        wait_busy();
        set_ptr(8'hFF, "R6 ptr");
        rx_byte(8'h5A, 1'b1, "R6 0xFF");
        rx_byte(8'hFF, 1'b1, "R6 wrap to 0x00");
        rx_byte(8'hFF, 1'b0, "R6 0x01");
        get_bit(b);
        check("R6 released after nack", {7'd0, b}, 8'h01);
        bus_stop();
        set_ptr(8'hF8, "R5 ptr");
        rx_byte(8'h6B, 1'b0, "R5 wrap 0xF8");
        bus_stop();

        // R9/R8: repeated start discards buffered data
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b1, "R9 wr");
        tx_byte(8'h40, 1'b1, "R9 word");
        tx_byte(8'h77, 1'b1, "R9 data");
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, "R9 rd after restart");
        rx_byte(8'hFF, 1'b0, "R9 0x41");
        bus_stop();
        bus_start();
        tx_byte(devb(AOK, 1'b0), 1'b1, "R9 no busy after discard");
        tx_byte(8'h40, 1'b1, "R8 word only");
        bus_stop();
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, "R8 no busy");
        rx_byte(8'hFF, 1'b0, "R9 0x40 not written");
        bus_stop();

        // R9: start and stop in the middle of a byte
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, "R9 start mid byte");
        rx_byte(8'hFF, 1'b0, "R9 0x41");
        bus_stop();
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        check("R9 released after stop", {7'd0, sda_pull}, 8'h00);
        bus_start();
        tx_byte(devb(AOK, 1'b1), 1'b1, "R9 after mid stop");
        rx_byte(8'hFF, 1'b0, "R9 0x42");
        bus_stop();

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) check("SB-leftover", 8'(exp_q.size()), 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule